// File: doc/BRIEF.md
# Multiplexed Grid Display Driver with Pulse-Width Dimming

This block scans a common-cathode LED panel of five grids and ten segments, one grid at a time. The patterns come from a ten-byte display RAM. Each grid owns two neighbouring bytes. At the start of each grid slot the block reads that grid's even byte and then its odd byte, one per clock cycle, from a RAM read port whose data is valid in the same cycle as the address. It then holds the grid on for sixteen sub-ticks. A sub-tick advances only on a clock where `slot_tick` is high. Within the slot, the segments are lit only during the leading part, whose length is set by a 3-bit dimming code from a non-linear table in sixteenths.

The dimming code and the display-enable bit are sampled once per slot. When the display is disabled, every grid and segment output is inactive, but the scan keeps running and the frame-end pulse keeps coming, so a key sampler paced by that pulse still works. A build-time option darkens the segments on the first and last sub-tick of each slot to suppress ghosting. The grid stays enabled through those sub-ticks.

The controller is a three-state machine:
- `ST_FETCH_LO` reads the even byte.
- `ST_FETCH_HI` reads the odd byte and samples the settings.
- `ST_SCAN` counts sub-ticks.

Its transitions are:
- **reset** goes to `ST_FETCH_LO`.
- **fetch-lo done**: `ST_FETCH_LO` to `ST_FETCH_HI`, always after one cycle.
- **fetch-hi done**: `ST_FETCH_HI` to `ST_SCAN`, always after one cycle.
- **slot end**: `ST_SCAN` to `ST_FETCH_LO`, on a `slot_tick` during the last sub-tick. The grid index advances and wraps from 4 to 0.
- **hold**: `ST_SCAN` stays in `ST_SCAN` in every other case.

Top module: `grid_mux_driver`

## Requirements
- R1: Grids are served in the order 0,1,2,3,4,0,... Each slot is one `ST_FETCH_LO` cycle, one `ST_FETCH_HI` cycle, then `ST_SCAN` until sixteen sub-ticks have passed. `grid_idx` shows the grid being served. During `ST_SCAN` with the display on, exactly `grid_n[grid_idx]` is low. In the fetch cycles all grid lines are high.
- R2: `ram_rd_addr` is 2·g in `ST_FETCH_LO` and in `ST_SCAN`, and 2·g+1 in `ST_FETCH_HI`, where g is the grid index. `ram_rd_data` is taken in the same cycle.
- R3: While segments are lit, `seg_en[7:0]` equals the even byte (bit 0 is the first segment) and `seg_en[9:8]` equals bits 1:0 of the odd byte.
- R4: Segments are lit only on sub-ticks whose index (0..15) is below the on-time of the sampled code. The on-times for codes 000..111 are 1, 2, 4, 10, 11, 12, 13 and 14 sixteenths.
- R5: With the sampled display-enable low, `seg_en` is zero and `grid_n` is all ones, while scanning and frame-end pulses continue.
- R6: `frame_end` is high for exactly the one clock in which `slot_tick` is high on sub-tick 15 of grid 4.
- R7: `dim_code` and `disp_on` are sampled in the `ST_FETCH_HI` cycle and hold for the whole slot that follows.
- R8: A clock with `slot_tick` low leaves the sub-tick count and all outputs unchanged.
- R9: After reset the block is in `ST_FETCH_LO` on grid 0 with address 0. The display is off, the dimming code is 000 and `frame_end` is low.
- R10: With `BLANK_EDGES`=1, the segments are dark on sub-ticks 0 and 15, while the grid line stays active through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | Sub-tick advance enable |
| dim_code | input | 3 | Dimming code, sampled once per slot |
| disp_on | input | 1 | Display enable, sampled once per slot |
| ram_rd_data | input | 8 | Display RAM read data, valid in the same cycle as the address |
| ram_rd_addr | output | 4 | Display RAM read address |
| seg_en | output | 10 | Segment enables, active high |
| grid_n | output | 5 | Grid enables, active low |
| grid_idx | output | 3 | Index of the grid being served |
| frame_end | output | 1 | One-cycle pulse at the end of the last grid slot |

## Verification
A slot end and a settings change can fall in the same cycle. The bench changes `dim_code` and `disp_on` on arbitrary cycles while `slot_tick` follows a pseudo-random pattern. Some changes therefore land exactly on the `ST_FETCH_HI` cycle, and others land mid-slot. Its behavioural model applies a new setting only from the next sampling point, and every output is compared against that model on every clock. Frame-end pulses that coincide with a blanked display are counted to confirm that scanning survives blanking.

// File: rtl/grid_mux_pkg.sv
package grid_mux_pkg;

    localparam int SLOT_SUBTICKS = 16;

    typedef enum logic [1:0] {
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_SCAN
    } scan_state_t;

    // Lit sub-ticks per slot for each dimming code (non-linear, in sixteenths)
    function automatic logic [4:0] on_sixteenths(input logic [2:0] code);
        logic [4:0] n;
        unique case (code)
            3'd0: n = 5'd1;
            3'd1: n = 5'd2;
            3'd2: n = 5'd4;
            3'd3: n = 5'd10;
            3'd4: n = 5'd11;
            3'd5: n = 5'd12;
            3'd6: n = 5'd13;
            default: n = 5'd14;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/grid_scan_fsm.sv
module grid_scan_fsm
    import grid_mux_pkg::*;
#(
    parameter int NUM_GRIDS = 5,
    parameter int GRID_W    = 3,
    parameter int SUB_W     = 4,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    output scan_state_t       state,
    output logic [GRID_W-1:0] grid,
    output logic [SUB_W-1:0]  sub,
    output logic [ADDR_W-1:0] ram_rd_addr,
    output logic              load_lo,
    output logic              load_hi,
    output logic              frame_end
);

    scan_state_t       state_nx;
    logic [GRID_W-1:0] grid_nx;
    logic [SUB_W-1:0]  sub_nx;
    logic              last_sub;
    logic              last_grid;

    assign last_sub  = (sub == SUB_W'(SLOT_SUBTICKS - 1));
    assign last_grid = (grid == GRID_W'(NUM_GRIDS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH_LO;
            grid  <= '0;
            sub   <= '0;
        end else begin
            state <= state_nx;
            grid  <= grid_nx;
            sub   <= sub_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        grid_nx  = grid;
        sub_nx   = sub;
        unique case (state)
            ST_FETCH_LO: state_nx = ST_FETCH_HI;
            ST_FETCH_HI: begin
                state_nx = ST_SCAN;
                sub_nx   = '0;
            end
            ST_SCAN: begin
                if (slot_tick) begin
                    if (last_sub) begin
                        sub_nx   = '0;
                        state_nx = ST_FETCH_LO;
                        grid_nx  = last_grid ? '0 : grid + GRID_W'(1);
                    end else begin
                        sub_nx = sub + SUB_W'(1);
                    end
                end
            end
            default: state_nx = ST_FETCH_LO;
        endcase
    end

    // Outputs
    always_comb begin
        load_lo     = 1'b0;
        load_hi     = 1'b0;
        frame_end   = 1'b0;
        ram_rd_addr = ADDR_W'({grid, 1'b0});
        unique case (state)
            ST_FETCH_LO: load_lo = 1'b1;
            ST_FETCH_HI: begin
                load_hi     = 1'b1;
                ram_rd_addr = ADDR_W'({grid, 1'b1});
            end
            ST_SCAN:     frame_end = slot_tick && last_sub && last_grid;
            default:     ;
        endcase
    end

endmodule

// File: rtl/grid_slot_latch.sv
module grid_slot_latch #(
    parameter int SEG_HI = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [7:0]        ram_rd_data,
    input  logic [2:0]        dim_code,
    input  logic              disp_on,
    output logic [7:0]        lo_q,
    output logic [SEG_HI-1:0] hi_q,
    output logic [2:0]        dim_q,
    output logic              on_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            dim_q <= 3'd0;
            on_q  <= 1'b0;
        end else begin
            if (load_lo) lo_q <= ram_rd_data;
            if (load_hi) begin
                hi_q  <= ram_rd_data[SEG_HI-1:0];
                dim_q <= dim_code;
                on_q  <= disp_on;
            end
        end
    end

endmodule

// File: rtl/grid_seg_gate.sv
module grid_seg_gate
    import grid_mux_pkg::*;
#(
    parameter int NUM_GRIDS   = 5,
    parameter int SEGS        = 10,
    parameter int GRID_W      = 3,
    parameter int SUB_W       = 4,
    parameter bit BLANK_EDGES = 1'b0
) (
    input  scan_state_t        state,
    input  logic [GRID_W-1:0]  grid,
    input  logic [SUB_W-1:0]   sub,
    input  logic [7:0]         lo_q,
    input  logic [SEGS-9:0]    hi_q,
    input  logic [2:0]         dim_q,
    input  logic               on_q,
    output logic [SEGS-1:0]    seg_en,
    output logic [NUM_GRIDS-1:0] grid_n
);

    logic grid_live;
    logic in_pulse;
    logic edge_ok;

    assign grid_live = (state == ST_SCAN) && on_q;
    assign in_pulse  = ({1'b0, sub} < on_sixteenths(dim_q));

    generate
        if (BLANK_EDGES) begin : g_edge_blank
            assign edge_ok = (sub != '0) && (sub != SUB_W'(SLOT_SUBTICKS - 1));
        end else begin : g_no_blank
            assign edge_ok = 1'b1;
        end
    endgenerate

    generate
        for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid_drv
            assign grid_n[g] = !(grid_live && (grid == GRID_W'(g)));
        end
    endgenerate

    assign seg_en = (grid_live && in_pulse && edge_ok) ? {hi_q, lo_q} : '0;

endmodule

// File: rtl/grid_mux_driver.sv
module grid_mux_driver
    import grid_mux_pkg::*;
#(
    parameter int NUM_GRIDS   = 5,
    parameter int SEGS        = 10,
    parameter bit BLANK_EDGES = 1'b0,
    localparam int GRID_W     = $clog2(NUM_GRIDS),
    localparam int ADDR_W     = $clog2(2 * NUM_GRIDS),
    localparam int SUB_W      = $clog2(SLOT_SUBTICKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_tick,
    input  logic [2:0]           dim_code,
    input  logic                 disp_on,
    input  logic [7:0]           ram_rd_data,
    output logic [ADDR_W-1:0]    ram_rd_addr,
    output logic [SEGS-1:0]      seg_en,
    output logic [NUM_GRIDS-1:0] grid_n,
    output logic [GRID_W-1:0]    grid_idx,
    output logic                 frame_end
);

    localparam int SEG_HI = SEGS - 8;

    scan_state_t       state;
    logic [GRID_W-1:0] grid;
    logic [SUB_W-1:0]  sub;
    logic              load_lo, load_hi;
    logic [7:0]        lo_q;
    logic [SEG_HI-1:0] hi_q;
    logic [2:0]        dim_q;
    logic              on_q;

    grid_scan_fsm #(
        .NUM_GRIDS(NUM_GRIDS), .GRID_W(GRID_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
        .state(state), .grid(grid), .sub(sub), .ram_rd_addr(ram_rd_addr),
        .load_lo(load_lo), .load_hi(load_hi), .frame_end(frame_end)
    );

    grid_slot_latch #(.SEG_HI(SEG_HI)) latch_i (
        .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .load_hi(load_hi),
        .ram_rd_data(ram_rd_data), .dim_code(dim_code), .disp_on(disp_on),
        .lo_q(lo_q), .hi_q(hi_q), .dim_q(dim_q), .on_q(on_q)
    );

    grid_seg_gate #(
        .NUM_GRIDS(NUM_GRIDS), .SEGS(SEGS), .GRID_W(GRID_W), .SUB_W(SUB_W),
        .BLANK_EDGES(BLANK_EDGES)
    ) gate_i (
        .state(state), .grid(grid), .sub(sub), .lo_q(lo_q), .hi_q(hi_q),
        .dim_q(dim_q), .on_q(on_q), .seg_en(seg_en), .grid_n(grid_n)
    );

    assign grid_idx = grid;

endmodule

// File: rtl/grid_mux_checker.sv
module grid_mux_checker #(
    parameter int NUM_GRIDS = 5,
    parameter int SEGS      = 10,
    parameter int GRID_W    = 3,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 slot_tick,
    input logic [ADDR_W-1:0]    ram_rd_addr,
    input logic [SEGS-1:0]      seg_en,
    input logic [NUM_GRIDS-1:0] grid_n,
    input logic [GRID_W-1:0]    grid_idx,
    input logic                 frame_end
);

    // R1
    one_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~grid_n));

    // R1
    grid_matches_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_n != '1) |-> (grid_n[grid_idx] == 1'b0));

    // R5
    seg_needs_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en != '0) |-> (grid_n != '1));

    // R6
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R6
    frame_last_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (slot_tick && grid_idx == GRID_W'(NUM_GRIDS - 1)));

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (grid_idx == '0));

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_addr < ADDR_W'(2 * NUM_GRIDS));

endmodule

bind grid_mux_driver grid_mux_checker #(
    .NUM_GRIDS(NUM_GRIDS), .SEGS(SEGS), .GRID_W(GRID_W), .ADDR_W(ADDR_W)
) grid_mux_chk_i (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .ram_rd_addr(ram_rd_addr),
    .seg_en(seg_en), .grid_n(grid_n), .grid_idx(grid_idx), .frame_end(frame_end)
);

// File: tb/grid_mux_driver_tb_top.sv
`timescale 1ns/1ps
module grid_mux_driver_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_tick = 1'b0;
    logic [2:0] dim_code = 3'd0;
    logic       disp_on = 1'b0;

    logic [7:0] bram [10];

    logic [3:0] addr_a, addr_b;
    logic [7:0] data_a, data_b;
    logic [9:0] seg_a, seg_b;
    logic [4:0] gn_a, gn_b;
    logic [2:0] gi_a, gi_b;
    logic       fe_a, fe_b;

    int n_tests = 0;
    int n_fail  = 0;
    int fe_seen = 0;

    always #10 clk = ~clk;

    assign data_a = (addr_a < 4'd10) ? bram[addr_a] : 8'h00;
    assign data_b = (addr_b < 4'd10) ? bram[addr_b] : 8'h00;

    grid_mux_driver dut_i (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .dim_code(dim_code),
        .disp_on(disp_on), .ram_rd_data(data_a), .ram_rd_addr(addr_a),
        .seg_en(seg_a), .grid_n(gn_a), .grid_idx(gi_a), .frame_end(fe_a)
    );

    grid_mux_driver #(.BLANK_EDGES(1'b1)) dut_blank_i (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .dim_code(dim_code),
        .disp_on(disp_on), .ram_rd_data(data_b), .ram_rd_addr(addr_b),
        .seg_en(seg_b), .grid_n(gn_b), .grid_idx(gi_b), .frame_end(fe_b)
    );

    // Behavioural reference model
    int         m_ph;   // 0 fetch even, 1 fetch odd, 2 scanning
    int         m_g;
    int         m_s;
    logic [7:0] m_lo;
    logic [1:0] m_hi;
    int         m_dim;
    bit         m_on;

    function automatic int lit_len(int code);
        int t[8] = '{1, 2, 4, 10, 11, 12, 13, 14};
        return t[code];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_g = 0; m_s = 0; m_lo = 0; m_hi = 0; m_dim = 0; m_on = 0;
        end else if (m_ph == 0) begin
            m_lo = bram[2*m_g];
            m_ph = 1;
        end else if (m_ph == 1) begin
            m_hi  = bram[2*m_g+1][1:0];
            m_dim = dim_code;
            m_on  = disp_on;
            m_s   = 0;
            m_ph  = 2;
        end else if (slot_tick) begin
            if (m_s == 15) begin
                m_s = 0; m_ph = 0; m_g = (m_g + 1) % 5;
            end else begin
                m_s++;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit   active, lit;
        int   e_addr, e_gn, e_seg, e_segb, e_fe;
        active = (m_ph == 2) && m_on;
        lit    = active && (m_s < lit_len(m_dim));
        e_addr = (m_ph == 1) ? 2*m_g + 1 : 2*m_g;
        e_gn   = active ? (~(1 << m_g)) & 5'h1f : 5'h1f;
        e_seg  = lit ? {m_hi, m_lo} : 0;
        e_segb = (lit && m_s != 0 && m_s != 15) ? {m_hi, m_lo} : 0;
        e_fe   = (m_ph == 2 && slot_tick && m_s == 15 && m_g == 4) ? 1 : 0;
        chk("R2 address", addr_a, e_addr);
        chk("R1 grid index", gi_a, m_g);
        chk("R1/R5 grid lines", gn_a, e_gn);
        chk("R3/R4/R5/R7/R8 segments", seg_a, e_seg);
        chk("R6 frame end", fe_a, e_fe);
        chk("R10 blanked segments", seg_b, e_segb);
        chk("R10 blanked grid lines", gn_b, e_gn);
        if (fe_a) fe_seen++;
    endtask

    task automatic step(bit tk);
        @(negedge clk);
        slot_tick = tk;
        #8;
        compare();
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] lfsr;
        for (int i = 0; i < 10; i++) bram[i] = 8'(8'h5A ^ (i * 8'h1D));
        repeat (3) @(negedge clk);
        #8;
        // R9: reset state
        chk("R9 reset addr", addr_a, 0);
        chk("R9 reset grid", gi_a, 0);
        chk("R9 reset grid lines", gn_a, 5'h1f);
        chk("R9 reset segments", seg_a, 0);
        chk("R9 reset frame end", fe_a, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #8;
        compare();

        // R5: display off, scanning continues
        fe_seen = 0;
        disp_on = 1'b1;  // applied only after reset sampling happens in fetch
        disp_on = 1'b0;
        for (int i = 0; i < 199; i++) step(1'b1);
        chk("R5 frame pulses while blanked", fe_seen, 2);

        // R4/R3: every dimming code with display on
        disp_on = 1'b1;
        for (int d = 0; d < 8; d++) begin
            dim_code = 3'(d);
            bram[d] = 8'(8'hC3 + d * 8'h11);
            bram[9 - d] = 8'(~bram[d]);
            for (int i = 0; i < 180; i++) step(1'b1);
        end

        // R7/R8: irregular ticks with settings changing at arbitrary cycles
        lfsr = 8'hA7;
        for (int i = 0; i < 900; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (i % 23 == 0) dim_code = lfsr[2:0];
            if (i % 97 == 0) disp_on = ~disp_on;
            if (i % 61 == 0) bram[lfsr[7:4] % 10] = lfsr;
            step(lfsr[0] | lfsr[6]);
        end

        // R8: long tick stall mid-slot
        disp_on = 1'b1;
        dim_code = 3'd7;
        for (int i = 0; i < 25; i++) step(1'b1);
        for (int i = 0; i < 40; i++) step(1'b0);
        for (int i = 0; i < 200; i++) step(1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule